// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block generates addresses for one port of a synchronous memory during bursts. A load strobe presets an 18-bit counter. Each enabled clock then advances only the low-order address bits that a mask register selects. Bits above the mask keep their loaded value. A mirror register keeps the last loaded start address. A retransmit request, or the wrap-around at the end of a burst, can jump back to that address.

When the selected low bits reach all ones, the next increment wraps. The wrap-select input chooses the result: the selected bits clear to zero, or the whole counter reloads from the mirror. A registered, active-low interrupt marks the cycle in which counting has filled the selected bits. Every operation takes effect on the next rising clock edge. The new address is visible on `addr_o` right after that edge.

Top module: `burst_addr_counter`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `addr_o` is 0, `cnt_int_no` is 1 and the mask selects all 18 bits.
- R2: `load_i` high with `mask_sel_i` low writes `addr_i` into the counter and the mirror. `addr_o` shows the value after the next edge.
- R3: `load_i` high with `mask_sel_i` high writes the mask and leaves the counter unchanged. Mask bit 0 is always 1. Mask bit k (k≥1) is 1 only when `addr_i` bits 1 through k are all 1.
- R4: `cnt_en_i` high with no other control increments the masked bits by one. Bits outside the mask hold. With `cnt_en_i` low and no other control, `addr_o` holds.
- R5: An increment when the masked bits are all ones and `wrap_sel_i` is 0 clears the masked bits and keeps the other bits.
- R6: An increment when the masked bits are all ones and `wrap_sel_i` is 1 loads the whole counter from the mirror.
- R7: `retx_i` loads the counter from the mirror and leaves the mirror unchanged.
- R8: `cnt_rst_i` clears the counter and the mirror to 0 and sets the mask to all ones.
- R9: The controls have a fixed priority: `cnt_rst_i` first, then `load_i`, then `retx_i`, then `cnt_en_i`.
- R10: `cnt_int_no` goes to 0 in the cycle after an increment makes the masked bits all ones. It stays 0 only while they remain all ones. A load that produces all ones does not drive it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 18 | Start address, or mask pattern when `mask_sel_i` is high |
| load_i | input | 1 | Load strobe, active high |
| mask_sel_i | input | 1 | Directs a load into the mask register |
| cnt_en_i | input | 1 | Increment enable |
| cnt_rst_i | input | 1 | Synchronous counter reset |
| retx_i | input | 1 | Retransmit: reload counter from the mirror |
| wrap_sel_i | input | 1 | Wrap action: 0 clears the masked bits, 1 reloads the mirror |
| addr_o | output | 18 | Current counter address |
| cnt_int_no | output | 1 | Counter-full interrupt, active low |

## Verification
On every cycle, the assertions check the following: the bits above the mask hold during an increment, both wrap outcomes, the load and retransmit transfers, the reset values, and the mask keeping a contiguous shape anchored at bit 0. They also check that the interrupt is low only while the masked bits are full. Other behaviour can only be shown by the directed scenarios. These cover the exact mask decoded from a pattern with bit 0 clear, the mask width observed through count length, priority when several controls coincide, and the rule that a load to all ones leaves the interrupt high.

// File: rtl/burst_cnt_pkg.sv
package burst_cnt_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLEAR,
    OP_LOAD_ADDR,
    OP_LOAD_MASK,
    OP_RETX,
    OP_STEP
  } cnt_op_e;
endpackage

// File: rtl/burst_cnt_ctrl.sv
module burst_cnt_ctrl
  import burst_cnt_pkg::*;
(
  input  logic    load_i,
  input  logic    mask_sel_i,
  input  logic    cnt_en_i,
  input  logic    cnt_rst_i,
  input  logic    retx_i,
  output cnt_op_e op_o
);
  // fixed priority: reset > load > retransmit > increment
  always_comb begin
    if (cnt_rst_i)      op_o = OP_CLEAR;
    else if (load_i)    op_o = mask_sel_i ? OP_LOAD_MASK : OP_LOAD_ADDR;
    else if (retx_i)    op_o = OP_RETX;
    else if (cnt_en_i)  op_o = OP_STEP;
    else                op_o = OP_IDLE;
  end
endmodule

// File: rtl/burst_cnt_mask.sv
module burst_cnt_mask
  import burst_cnt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mask_o,
  output logic [ADDR_W-1:0] mask_d_o
);
  logic [ADDR_W-1:0] mask_q, shaped;

  // contiguous run from bit 0; bit 0 always selected
  assign shaped[0] = 1'b1;
  for (genvar k = 1; k < ADDR_W; k++) begin : g_shape
    assign shaped[k] = shaped[k-1] & addr_i[k];
  end

  always_comb begin
    mask_d_o = mask_q;
    case (op_i)
      OP_CLEAR:     mask_d_o = '1;
      OP_LOAD_MASK: mask_d_o = shaped;
      default:      mask_d_o = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d_o;
  end

  assign mask_o = mask_q;

  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[0] && ((mask_q & (mask_q + 1'b1)) == '0)); // R3
  AST_MASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLEAR) |=> (mask_q == '1)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_IDLE, OP_STEP, OP_RETX, OP_LOAD_ADDR}) |=> $stable(mask_q)); // R4
endmodule

// File: rtl/burst_cnt_core.sv
module burst_cnt_core
  import burst_cnt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              wrap_sel_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic [ADDR_W-1:0] cnt_d_o,
  output logic              fill_step_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] cnt_q, mirror_q, mirror_d, bumped;
  logic              at_max;

  assign at_max = ((cnt_q & mask_i) == mask_i);
  assign bumped = (cnt_q & ~mask_i) | ((cnt_q + ONE) & mask_i);

  always_comb begin
    cnt_d_o     = cnt_q;
    mirror_d    = mirror_q;
    fill_step_o = 1'b0;
    case (op_i)
      OP_CLEAR: begin
        cnt_d_o  = '0;
        mirror_d = '0;
      end
      OP_LOAD_ADDR: begin
        cnt_d_o  = addr_i;
        mirror_d = addr_i;
      end
      OP_RETX: cnt_d_o = mirror_q;
      OP_STEP: begin
        if (at_max) begin
          cnt_d_o = wrap_sel_i ? mirror_q : (cnt_q & ~mask_i);
        end else begin
          cnt_d_o     = bumped;
          fill_step_o = 1'b1;
        end
      end
      default: cnt_d_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      mirror_q <= '0;
    end else begin
      cnt_q    <= cnt_d_o;
      mirror_q <= mirror_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_LOAD_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD_ADDR) |=> (cnt_q == $past(addr_i)) && (mirror_q == $past(addr_i))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDLE) |=> $stable(cnt_q)); // R4
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP && !(at_max && wrap_sel_i)) |=>
      ((cnt_q & ~mask_i) == $past(cnt_q & ~mask_i))); // R4
  AST_WRAP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP && at_max && !wrap_sel_i) |=> ((cnt_q & mask_i) == '0)); // R5
  AST_WRAP_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP && at_max && wrap_sel_i) |=> (cnt_q == $past(mirror_q))); // R6
  AST_RETX_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RETX) |=> (cnt_q == $past(mirror_q)) && $stable(mirror_q)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLEAR) |=> (cnt_q == '0) && (mirror_q == '0)); // R8
endmodule

// File: rtl/burst_cnt_irq.sv
module burst_cnt_irq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cnt_d_i,
  input  logic [ADDR_W-1:0] mask_d_i,
  input  logic              fill_step_i,
  output logic              int_no
);
  logic full_d, low_q, low_d;

  assign full_d = ((cnt_d_i & mask_d_i) == mask_d_i);
  // set only by counting into full; kept while still full
  assign low_d  = full_d && (fill_step_i || low_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= low_d;
  end

  assign int_no = ~low_q;

  AST_INT_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_step_i && full_d) |=> !int_no); // R10
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_cnt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              mask_sel_i,
  input  logic              cnt_en_i,
  input  logic              cnt_rst_i,
  input  logic              retx_i,
  input  logic              wrap_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cnt_int_no
);
  cnt_op_e           op;
  logic [ADDR_W-1:0] mask_q, mask_d, cnt_d;
  logic              fill_step;

  burst_cnt_ctrl u_ctrl (
    .load_i     (load_i),
    .mask_sel_i (mask_sel_i),
    .cnt_en_i   (cnt_en_i),
    .cnt_rst_i  (cnt_rst_i),
    .retx_i     (retx_i),
    .op_o       (op)
  );

  burst_cnt_mask #(.ADDR_W(ADDR_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .addr_i   (addr_i),
    .mask_o   (mask_q),
    .mask_d_o (mask_d)
  );

  burst_cnt_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .addr_i      (addr_i),
    .mask_i      (mask_q),
    .wrap_sel_i  (wrap_sel_i),
    .cnt_o       (addr_o),
    .cnt_d_o     (cnt_d),
    .fill_step_o (fill_step)
  );

  burst_cnt_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_d_i     (cnt_d),
    .mask_d_i    (mask_d),
    .fill_step_i (fill_step),
    .int_no      (cnt_int_no)
  );

  AST_INT_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_int_no |-> ((addr_o & mask_q) == mask_q)); // R10
  AST_RST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_i |=> (addr_o == '0) && cnt_int_no); // R9
  AST_LOAD_OVER_RETX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_rst_i && load_i && !mask_sel_i) |=> (addr_o == $past(addr_i))); // R9
endmodule

// File: tb/burst_addr_counter_tb.sv
module burst_addr_counter_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ld = 0, msel = 0, en = 0, crst = 0, rtx = 0, wrap = 0;
  logic [AW-1:0] addr_o;
  logic          int_n;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .load_i(ld), .mask_sel_i(msel),
    .cnt_en_i(en), .cnt_rst_i(crst), .retx_i(rtx), .wrap_sel_i(wrap),
    .addr_o(addr_o), .cnt_int_no(int_n)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clocked cycle of controls, then back to idle; outputs settled at return
  task automatic cyc(input logic l, input logic m, input logic e, input logic r,
                     input logic t, input logic w, input logic [AW-1:0] a);
    ld = l; msel = m; en = e; crst = r; rtx = t; wrap = w; addr = a;
    @(posedge clk);
    @(negedge clk);
    ld = 0; msel = 0; en = 0; crst = 0; rtx = 0; wrap = 0; addr = '0;
  endtask

  task automatic load_addr(input logic [AW-1:0] a); cyc(1,0,0,0,0,0,a); endtask
  task automatic load_mask(input logic [AW-1:0] a); cyc(1,1,0,0,0,0,a); endtask
  task automatic step(input logic w);               cyc(0,0,1,0,0,w,'0); endtask

  task automatic t_reset;
    chk("R1 addr", addr_o, '0);
    chk("R1 int", {17'd0, int_n}, 18'd1);
    step(0);
    chk("R1 full mask counts from 0", addr_o, 18'd1);
  endtask

  task automatic t_load_step;
    load_addr(18'h2A5F3);
    chk("R2 load", addr_o, 18'h2A5F3);
    cyc(0,0,0,0,0,0,18'h11111);
    chk("R4 hold when disabled", addr_o, 18'h2A5F3);
    step(0);
    chk("R4 increment", addr_o, 18'h2A5F4);
  endtask

  task automatic t_mask_wrap_clear;
    load_addr(18'h3FF0C);
    load_mask(18'h0000F);
    chk("R3 mask load keeps counter", addr_o, 18'h3FF0C);
    step(0); chk("R4 step", addr_o, 18'h3FF0D);
    chk("R10 not full", {17'd0, int_n}, 18'd1);
    step(0); step(0);
    chk("R4 step to full", addr_o, 18'h3FF0F);
    chk("R10 int low at full", {17'd0, int_n}, 18'd0);
    cyc(0,0,0,0,0,0,'0);
    chk("R10 int stays low while full", {17'd0, int_n}, 18'd0);
    step(0);
    chk("R5 wrap clears masked bits", addr_o, 18'h3FF00);
    chk("R10 int high after wrap", {17'd0, int_n}, 18'd1);
  endtask

  task automatic t_mask_shape_mirror;
    load_mask(18'h00006);   // bit0 clear: mask becomes 0x7
    load_addr(18'h00010);
    for (int i = 0; i < 7; i++) step(1);
    chk("R3 mask width 3 bits", addr_o, 18'h00017);
    chk("R10 int at full", {17'd0, int_n}, 18'd0);
    step(1);
    chk("R6 wrap reloads mirror", addr_o, 18'h00010);
    load_mask(18'h0000D);   // bits1..3 = 0,1,1 -> mask 0x1
    load_addr(18'h00020);
    step(0);
    chk("R3 mask only bit0", addr_o, 18'h00021);
    step(0);
    chk("R5 single-bit wrap", addr_o, 18'h00020);
  endtask

  task automatic t_retx;
    load_mask(18'h00007);
    load_addr(18'h00155);
    step(0); step(0);
    chk("R4 count", addr_o, 18'h00157);
    cyc(0,0,0,0,1,0,'0);
    chk("R7 retransmit", addr_o, 18'h00155);
    chk("R10 int clears off full", {17'd0, int_n}, 18'd1);
    step(0);
    cyc(0,0,0,0,1,0,'0);
    chk("R7 mirror unchanged", addr_o, 18'h00155);
  endtask

  task automatic t_load_full_no_int;
    load_addr(18'h0003F);
    chk("R2 load", addr_o, 18'h0003F);
    chk("R10 load to full leaves int high", {17'd0, int_n}, 18'd1);
    step(0);
    chk("R5 wrap", addr_o, 18'h00038);
  endtask

  task automatic t_priority;
    load_addr(18'h00AB0);
    cyc(1,0,1,1,1,1,18'h12345);
    chk("R9 reset beats all", addr_o, '0);
    for (int i = 0; i < 9; i++) step(0);
    chk("R8 mask all ones after reset", addr_o, 18'd9);
    step(1); // not full: normal increment
    cyc(0,0,0,0,1,0,'0);
    chk("R8 mirror cleared", addr_o, '0);
    load_addr(18'h00100);
    cyc(1,0,1,0,1,0,18'h00222);
    chk("R9 load beats retx and step", addr_o, 18'h00222);
    step(0);
    cyc(0,0,1,0,1,0,'0);
    chk("R9 retx beats step", addr_o, 18'h00222);
    cyc(1,1,1,0,1,0,18'h00003);
    chk("R9 mask load beats retx", addr_o, 18'h00222);
    step(0);
    chk("R3 mask 0x3 after priority", addr_o, 18'h00223);
    step(0);
    chk("R5 mask 0x3 wraps", addr_o, 18'h00220);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_step();
    t_mask_wrap_clear();
    t_mask_shape_mirror();
    t_retx();
    t_load_full_no_int();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule